// File: doc/BRIEF.md
# Credit-Gated Round-Robin DRAM Issue Arbiter

Several sub-partition request queues share one DRAM command input. Each cycle this block looks at the heads of those queues and grants at most one of them. The granted queue is popped and its request goes to the DRAM. A requester takes part only when three things hold: its queue has a request, its return path has room, and it can claim a credit. Credits bound the number of requests that are in flight between the DRAM and the return queues.

The credits come in two tiers. Each requester owns a small private allowance, which guarantees that it can always make progress. Beyond that allowance, a requester draws on a pool that all requesters share. The pool size is derived from the scheduler, return and optional write queue depths. A credit is consumed when a request is granted. It comes back on one of two return channels:
- read responses return their credit when they enter the return queue;
- writebacks return their credit on their completion strobe.

The search rotates. It begins at the requester after the last one granted. When the first eligible candidate finds the DRAM full for its direction (read or write), the search ends for that cycle. The arbiter does not fall through to a later requester.

Top module: `cgrr_dram_arbiter`

## Requirements
- R1: After reset nothing is granted while no request is valid, no error flag is raised, every credit is free, and the first search begins at requester 0.
- R2: A requester is eligible only when its `req_valid` is 1, its `ret_full` is 0 and it can claim a credit. Requesters that are not eligible are skipped.
- R3: At most one bit of `pop` is set in a cycle. When `grant_vld` is 1, `pop` is one-hot at bit `grant_id`. Otherwise `pop` is all zero.
- R4: The search starts at the index one above the last granted requester and wraps modulo N. The last granted requester is updated only on a grant.
- R5: The first eligible requester in search order is the candidate. The DRAM full flag for its direction is `dram_wr_full` when `req_is_wr` is 1 and `dram_rd_full` when it is 0. If that flag is set, no grant is made that cycle, even if later requesters are eligible.
- R6: A grant takes a private credit (one per requester by default) when the requester's private count is below its limit. Otherwise the grant takes a shared credit.
- R7: The shared pool limit is the scheduler depth plus the return depth minus (N-1), plus the write queue depth when the separate write queue is enabled. The defaults give a limit of 3. A requester whose private credit is used while the pool is at its limit is not eligible.
- R8: A returned credit decrements the requester's private count when that count is nonzero. Otherwise it decrements the shared count.
- R9: Credits return on the read-response channel and on the writeback-completion channel, and both can fire in the same cycle (response first). Returns are applied before that cycle's grant decision.
- R10: A return that finds both the private count and the shared count at zero raises `err_orphan_ret` in that cycle and changes no count.
- R11: When the scheduler depth or the return depth is 0, the shared pool has no limit, and a requester is never refused for lack of credit.
- R12: `err_dry_borrow` is raised when a grant is made to a requester that has no credit available. It stays 0 in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Outgoing queue of each requester is not empty |
| req_is_wr | input | N | Head request of each requester is a write |
| ret_full | input | N | Return queue of each requester is full |
| dram_rd_full | input | 1 | DRAM cannot accept a read |
| dram_wr_full | input | 1 | DRAM cannot accept a write |
| rsp_ret_vld | input | 1 | Read response entered a return queue; release a credit |
| rsp_ret_id | input | log2 N | Requester of that response |
| wb_done_vld | input | 1 | Writeback completed; release a credit |
| wb_done_id | input | log2 N | Requester of that writeback |
| grant_vld | output | 1 | A request is issued this cycle |
| grant_id | output | log2 N | Index of the granted requester |
| pop | output | N | One-hot pop of the granted queue |
| err_dry_borrow | output | 1 | Grant made with no credit available |
| err_orphan_ret | output | 1 | Credit returned with nothing outstanding |

## Verification
Two conditions are hard to reach. The first is a credit that comes back in the same cycle a starved requester asks again; the second is a return that falls through to the shared pool. To reach them, the stimulus first uses up every private credit and fills the shared pool to its limit, then returns a credit in the very cycle the starved requester asks. It also fires both return channels at one requester together, so that the second return reaches the shared count. The orphan return is reached by draining every credit and then returning one more. After that, a fresh round of grants shows that the counts did not wrap. A second instance built with a zero scheduler depth is granted repeatedly past the point where the limited instance stops.

// File: rtl/cgrr_arb_pkg.sv
package cgrr_arb_pkg;

    // Shared pool size: 0 means unlimited.
    function automatic int shared_pool_limit(
        input int sched_depth,
        input int ret_depth,
        input int wrq_depth,
        input bit sep_wrq,
        input int n_req
    );
        int lim;
        lim = sched_depth + ret_depth - (n_req - 1);
        if (sep_wrq) lim = lim + wrq_depth;
        if (sched_depth == 0 || ret_depth == 0) lim = 0;
        if (lim < 0) lim = 0;
        return lim;
    endfunction

    typedef enum logic [0:0] {
        RET_SRC_RSP = 1'b0,
        RET_SRC_WB  = 1'b1
    } ret_src_e;

endpackage

// File: rtl/cgrr_credit_ledger.sv
module cgrr_credit_ledger #(
    parameter int N_REQ        = 4,
    parameter int PRIV_LIMIT   = 1,
    parameter int SHARED_LIMIT = 3,
    parameter int SHARED_W     = 8,
    localparam int IDW         = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int PW          = $clog2(PRIV_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsp_vld,
    input  logic [IDW-1:0]   rsp_id,
    input  logic             wb_vld,
    input  logic [IDW-1:0]   wb_id,
    input  logic             brw_vld,
    input  logic [IDW-1:0]   brw_id,
    output logic [N_REQ-1:0] has_credit,
    output logic             err_borrow,
    output logic             err_orphan
);
    import cgrr_arb_pkg::*;

    localparam bit UNLIMITED = (SHARED_LIMIT == 0);

    typedef struct packed {
        logic [N_REQ-1:0][PW-1:0] priv;
        logic [SHARED_W-1:0]      shared;
    } ledger_t;

    ledger_t cur_q, mid_c, nxt_d;
    logic    orphan_c;
    logic    borrow_err_c;

    // Returns first, then credit availability.
    always_comb begin
        logic           rv;
        logic [IDW-1:0] rid;
        mid_c    = cur_q;
        orphan_c = 1'b0;
        for (int c = 0; c < 2; c++) begin
            rv  = (ret_src_e'(c) == RET_SRC_RSP) ? rsp_vld : wb_vld;
            rid = (ret_src_e'(c) == RET_SRC_RSP) ? rsp_id  : wb_id;
            if (rv) begin
                if (mid_c.priv[rid] != '0)
                    mid_c.priv[rid] = mid_c.priv[rid] - PW'(1);
                else if (mid_c.shared != '0)
                    mid_c.shared = mid_c.shared - SHARED_W'(1);
                else
                    orphan_c = 1'b1;
            end
        end
        for (int i = 0; i < N_REQ; i++) begin
            has_credit[i] = (mid_c.priv[i] < PW'(PRIV_LIMIT)) || UNLIMITED ||
                            (mid_c.shared < SHARED_W'(SHARED_LIMIT));
        end
    end

    // Borrow applied on top of the post-return counts.
    always_comb begin
        nxt_d        = mid_c;
        borrow_err_c = 1'b0;
        if (brw_vld) begin
            if (mid_c.priv[brw_id] < PW'(PRIV_LIMIT)) begin
                nxt_d.priv[brw_id] = mid_c.priv[brw_id] + PW'(1);
            end else if (UNLIMITED || (mid_c.shared < SHARED_W'(SHARED_LIMIT))) begin
                if (mid_c.shared != '1)
                    nxt_d.shared = mid_c.shared + SHARED_W'(1);
            end else begin
                borrow_err_c = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign err_borrow = borrow_err_c;
    assign err_orphan = orphan_c;

    logic priv_over_c;
    always_comb begin
        priv_over_c = 1'b0;
        for (int i = 0; i < N_REQ; i++)
            if (cur_q.priv[i] > PW'(PRIV_LIMIT)) priv_over_c = 1'b1;
    end

    AST_PRIV_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_over_c) else $error("private count above limit"); // R6

    AST_SHARED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        UNLIMITED || (cur_q.shared <= SHARED_W'(SHARED_LIMIT)))
        else $error("shared count above limit"); // R7

    AST_NO_DRY_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        brw_vld |-> !err_borrow) else $error("grant without credit"); // R12

    AST_ORPHAN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_orphan && !brw_vld && !(rsp_vld && wb_vld)) |=> $stable(cur_q))
        else $error("orphan return changed counts"); // R10

endmodule

// File: rtl/cgrr_rr_picker.sv
module cgrr_rr_picker #(
    parameter int N_REQ = 4,
    localparam int IDW  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_valid,
    input  logic [N_REQ-1:0] req_is_wr,
    input  logic [N_REQ-1:0] ret_full,
    input  logic [N_REQ-1:0] has_credit,
    input  logic             dram_rd_full,
    input  logic             dram_wr_full,
    output logic             gnt_vld,
    output logic [IDW-1:0]   gnt_id
);
    typedef struct packed {
        logic [IDW-1:0] last;
    } pick_t;

    pick_t cur_q, nxt_d;

    always_comb begin
        int   idx;
        logic stop;
        nxt_d   = cur_q;
        gnt_vld = 1'b0;
        gnt_id  = '0;
        stop    = 1'b0;
        for (int p = 0; p < N_REQ; p++) begin
            idx = (int'(cur_q.last) + 1 + p) % N_REQ;
            if (!stop && req_valid[idx] && has_credit[idx] && !ret_full[idx]) begin
                stop = 1'b1;
                if (!(req_is_wr[idx] ? dram_wr_full : dram_rd_full)) begin
                    gnt_vld = 1'b1;
                    gnt_id  = IDW'(idx);
                end
            end
        end
        if (gnt_vld) nxt_d.last = gnt_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q.last <= IDW'(N_REQ - 1);
        else        cur_q      <= nxt_d;
    end

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> (req_valid[gnt_id] && has_credit[gnt_id] && !ret_full[gnt_id]))
        else $error("grant to ineligible requester"); // R2

    AST_DRAM_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> !(req_is_wr[gnt_id] ? dram_wr_full : dram_rd_full))
        else $error("grant into full DRAM"); // R5

    AST_LAST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |=> (cur_q.last == $past(gnt_id)))
        else $error("rotation pointer not updated"); // R4

endmodule

// File: rtl/cgrr_dram_arbiter.sv
module cgrr_dram_arbiter #(
    parameter int N_REQ       = 4,
    parameter int PRIV_LIMIT  = 1,
    parameter int SCHED_DEPTH = 4,
    parameter int RET_DEPTH   = 2,
    parameter int WRQ_DEPTH   = 2,
    parameter bit SEP_WRQ_EN  = 1'b0,
    parameter int SHARED_W    = 8,
    localparam int IDW        = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_valid,
    input  logic [N_REQ-1:0] req_is_wr,
    input  logic [N_REQ-1:0] ret_full,
    input  logic             dram_rd_full,
    input  logic             dram_wr_full,
    input  logic             rsp_ret_vld,
    input  logic [IDW-1:0]   rsp_ret_id,
    input  logic             wb_done_vld,
    input  logic [IDW-1:0]   wb_done_id,
    output logic             grant_vld,
    output logic [IDW-1:0]   grant_id,
    output logic [N_REQ-1:0] pop,
    output logic             err_dry_borrow,
    output logic             err_orphan_ret
);
    import cgrr_arb_pkg::*;

    localparam int SHARED_LIMIT =
        shared_pool_limit(SCHED_DEPTH, RET_DEPTH, WRQ_DEPTH, SEP_WRQ_EN, N_REQ);

    logic [N_REQ-1:0] credit_ok;
    logic             gnt_vld_w;
    logic [IDW-1:0]   gnt_id_w;

    cgrr_credit_ledger #(
        .N_REQ       (N_REQ),
        .PRIV_LIMIT  (PRIV_LIMIT),
        .SHARED_LIMIT(SHARED_LIMIT),
        .SHARED_W    (SHARED_W)
    ) u_ledger (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_vld   (rsp_ret_vld),
        .rsp_id    (rsp_ret_id),
        .wb_vld    (wb_done_vld),
        .wb_id     (wb_done_id),
        .brw_vld   (gnt_vld_w),
        .brw_id    (gnt_id_w),
        .has_credit(credit_ok),
        .err_borrow(err_dry_borrow),
        .err_orphan(err_orphan_ret)
    );

    cgrr_rr_picker #(
        .N_REQ(N_REQ)
    ) u_picker (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_is_wr   (req_is_wr),
        .ret_full    (ret_full),
        .has_credit  (credit_ok),
        .dram_rd_full(dram_rd_full),
        .dram_wr_full(dram_wr_full),
        .gnt_vld     (gnt_vld_w),
        .gnt_id      (gnt_id_w)
    );

    genvar g;
    generate
        for (g = 0; g < N_REQ; g++) begin : g_pop
            assign pop[g] = gnt_vld_w && (gnt_id_w == IDW'(g));
        end
    endgenerate

    assign grant_vld = gnt_vld_w;
    assign grant_id  = gnt_id_w;

    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop)) else $error("more than one pop"); // R3

    AST_POP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld == (pop != '0)) else $error("pop and grant disagree"); // R3

endmodule

// File: tb/cgrr_dram_arbiter_bench.sv
module cgrr_dram_arbiter_bench;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] v = '0, w = '0, rf = '0;
    logic       rdf = 1'b0, wdf = 1'b0;
    logic       rv = 1'b0, wv = 1'b0;
    logic [1:0] rid = '0, wid = '0;
    logic       gv;
    logic [1:0] gid;
    logic [3:0] pop;
    logic       e_dry, e_orph;

    logic [3:0] u_v = '0;
    logic       u_gv;
    logic [1:0] u_gid;
    logic [3:0] u_pop;
    logic       u_dry, u_orph;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    cgrr_dram_arbiter u_cgrr_dram_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(v), .req_is_wr(w), .ret_full(rf),
        .dram_rd_full(rdf), .dram_wr_full(wdf),
        .rsp_ret_vld(rv), .rsp_ret_id(rid), .wb_done_vld(wv), .wb_done_id(wid),
        .grant_vld(gv), .grant_id(gid), .pop(pop),
        .err_dry_borrow(e_dry), .err_orphan_ret(e_orph)
    );

    // Zero scheduler depth: unlimited shared pool.
    cgrr_dram_arbiter #(.SCHED_DEPTH(0)) u_cgrr_dram_arbiter_unl (
        .clk(clk), .rst_n(rst_n), .req_valid(u_v), .req_is_wr(4'b0000),
        .ret_full(4'b0000), .dram_rd_full(1'b0), .dram_wr_full(1'b0),
        .rsp_ret_vld(1'b0), .rsp_ret_id(2'd0), .wb_done_vld(1'b0), .wb_done_id(2'd0),
        .grant_vld(u_gv), .grant_id(u_gid), .pop(u_pop),
        .err_dry_borrow(u_dry), .err_orphan_ret(u_orph)
    );

    // Driver: drive one cycle of stimulus and queue the expectation.
    task automatic step(input logic [3:0] iv, input logic [3:0] iw, input logic [3:0] irf,
                        input logic irdf, input logic iwdf,
                        input logic irv, input logic [1:0] irid,
                        input logic iwv, input logic [1:0] iwid,
                        input logic eg, input logic [1:0] eid, input logic eorph,
                        input string tag);
        @(negedge clk);
        v = iv; w = iw; rf = irf; rdf = irdf; wdf = iwdf;
        rv = irv; rid = irid; wv = iwv; wid = iwid;
        exp_q.push_back({eorph, eg, eid, 1'b0});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the design's outputs against queued expectations.
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            string      t;
            logic [3:0] epop;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            epop = e[3] ? (4'b0001 << e[2:1]) : 4'b0000;
            checks++;
            if (gv !== e[3] || pop !== epop || (e[3] && gid !== e[2:1]) ||
                e_orph !== e[4] || e_dry !== 1'b0) begin
                fails++;
                $display("FAIL %s: got gv=%b id=%0d pop=%b orph=%b dry=%b, exp gv=%b id=%0d pop=%b orph=%b dry=0",
                         t, gv, gid, pop, e_orph, e_dry, e[3], e[2:1], epop, e[4]);
            end
        end
    end

    initial begin
        #(CLK_P*3000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hang, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        //    v       w       rf      rdf wdf rv rid  wv wid  g id  orph
        step(4'b0000,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 0,2'd0,0, "R1 idle after reset");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd0,0, "R1 R4 first search at 0");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd1,0, "R4 R6 rotate to 1");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd2,0, "R4 R6 rotate to 2");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd3,0, "R4 R6 rotate to 3");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd0,0, "R7 shared 1 wrap");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd1,0, "R7 shared 2");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd2,0, "R7 shared 3");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 0,2'd0,0, "R7 pool at limit");
        step(4'b0001,4'b0000,4'b0000,0,0, 1,2'd0, 0,2'd0, 1,2'd0,0, "R9 return before grant");
        step(4'b0000,4'b0000,4'b0000,0,0, 0,2'd0, 1,2'd1, 0,2'd0,0, "R9 writeback return");
        step(4'b0010,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd1,0, "R9 credit from writeback");
        step(4'b0000,4'b0000,4'b0000,0,0, 1,2'd2, 1,2'd2, 0,2'd0,0, "R8 dual return same id");
        step(4'b1000,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd3,0, "R8 shared freed");
        step(4'b0100,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd2,0, "R8 private freed");
        step(4'b0000,4'b0000,4'b0000,0,0, 1,2'd0, 1,2'd1, 0,2'd0,0, "R8 drain a");
        step(4'b0000,4'b0000,4'b0000,0,0, 1,2'd2, 1,2'd3, 0,2'd0,0, "R8 drain b");
        step(4'b0000,4'b0000,4'b0000,0,0, 1,2'd0, 1,2'd0, 0,2'd0,0, "R8 drain shared");
        step(4'b0000,4'b0000,4'b0000,0,0, 1,2'd1, 1,2'd1, 0,2'd0,1, "R10 orphan return");
        step(4'b1111,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd3,0, "R10 R4 counts intact");
        step(4'b1111,4'b0000,4'b0001,0,0, 0,2'd0, 0,2'd0, 1,2'd1,0, "R2 ret_full skipped");
        step(4'b1000,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd3,0, "R2 invalid skipped");
        step(4'b0101,4'b0001,4'b0000,0,1, 0,2'd0, 0,2'd0, 0,2'd0,0, "R5 write full aborts");
        step(4'b0101,4'b0001,4'b0000,1,0, 0,2'd0, 0,2'd0, 1,2'd0,0, "R5 write ignores read full");
        step(4'b0100,4'b0000,4'b0000,1,0, 0,2'd0, 0,2'd0, 0,2'd0,0, "R5 read full aborts");
        step(4'b0100,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 1,2'd2,0, "R5 R3 read resumes");
        step(4'b0000,4'b0000,4'b0000,0,0, 0,2'd0, 0,2'd0, 0,2'd0,0, "R12 idle end");
        repeat (3) @(negedge clk);

        // R11: unlimited pool keeps granting requester 0.
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            u_v = 4'b0001;
            #(CLK_P/4);
            checks++;
            if (u_pop !== 4'b0001 || u_gv !== 1'b1 || u_dry !== 1'b0) begin
                fails++;
                $display("FAIL R11 grant %0d: got pop=%b dry=%b, exp pop=0001 dry=0", k, u_pop, u_dry);
            end
        end
        @(negedge clk);
        u_v = '0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule